// File: doc/BRIEF.md
# Paced Scene Playback Word Sequencer

This block plays stored scene frames out to an emitter-array drive pipeline. On each frame-start strobe it fetches the words of a frame from a frame memory, one word at a time, through a simple request/response read port. It then sends each 64-bit word downstream as four 16-bit pixels on consecutive clocks. Words leave at a fixed, programmable pace. A base tick of 8 MHz is made by dividing the system clock by `TICK_DIV`, and one word slot opens every N base ticks, with N between 1 and 15.

Three playback modes set what happens from one frame to the next. Single-frame mode sends one frame and then waits for an explicit re-arm. Multiple-frame mode replays the same frame, from the same base address, on every strobe. Auto-repeat mode steps through consecutive frame-sized blocks of memory, like a movie, for a programmed number of frames.

If a word slot comes due before memory has returned the next word, the previous word is sent again and an underrun is flagged. A strobe that arrives while a frame is running is ignored and counted. The mode, base address, divisor and frame count are sampled when a frame begins.

Top module: `scene_word_sequencer`

## Requirements
- R1: After reset, `pix_valid`, `mem_req`, `underrun` and `busy` are low and `drop_count` is zero.
- R2: A word slot opens every `TICK_DIV`×N clocks, the first one `TICK_DIV`×N−1 clocks after the frame-start edge. N is taken from `cfg_div` when the frame begins, and a value of 0 is used as 1.
- R3: Each word delivered from memory appears as four pixels on four consecutive clocks with `pix_valid` high: bits 63:48 first, then 47:32, then 31:16, then 15:0.
- R4: A frame reads the word addresses base+0 up to base+`FRAME_WORDS`−1 in order. `mem_req` is a one-cycle request, and a new request is made only after the previous word has been returned and taken out of the one-word buffer.
- R5: Mode code 0 is single-frame, and code 3 behaves the same. After one frame the block holds, and frame-start strobes have no effect until `cfg_arm` is pulsed.
- R6: Mode code 1 is multiple-frame. Every frame-start strobe replays the frame from `cfg_base`.
- R7: Mode code 2 is auto-repeat. Frame k of a run starts at `cfg_base`+k×`FRAME_WORDS`. After `cfg_frames` frames (0 is used as 1) the block returns to idle, and the next strobe starts again at `cfg_base`. A `cfg_arm` pulse between frames also returns it to idle.
- R8: If no fetched word is buffered when a slot opens, the last word is output again and `underrun` is high during its first pixel. The frame still delivers all `FRAME_WORDS` fetched words.
- R9: A frame-start strobe while `busy` is high does not disturb the frame and increments `drop_count`, which saturates at its maximum value.
- R10: `busy` goes high on the clock edge that starts a frame and falls on the edge at which the frame's last fetched word enters the pixel output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Frame-start strobe, one clock per strobe |
| cfg_mode | input | 2 | Playback mode: 0 single, 1 multiple, 2 auto-repeat, 3 as single |
| cfg_base | input | ADDR_W | Word address of the first word of the frame or run |
| cfg_div | input | 4 | Word pacing divisor N (0 used as 1) |
| cfg_frames | input | FCNT_W | Frames per auto-repeat run (0 used as 1) |
| cfg_arm | input | 1 | Re-arm pulse after a single frame, or abort of an auto run |
| mem_req | output | 1 | Read request, one clock per word |
| mem_addr | output | ADDR_W | Word address of the request |
| mem_rvalid | input | 1 | Read data returned this clock |
| mem_rdata | input | 64 | Returned word |
| pix_valid | output | 1 | Pixel on `pix_data` is valid |
| pix_data | output | 16 | Pixel value |
| underrun | output | 1 | High with the first pixel of a repeated word |
| busy | output | 1 | A frame is in progress |
| drop_count | output | DROP_W | Count of frame-start strobes ignored during a frame |

## Verification
The bench goes after slot timing at N=3 and at N=0. A pacer that miscounts, or that forgets to map 0 to 1, would space the pixel bursts wrongly or stall. It checks the frame base across modes. A wrong addressing mode would replay where it should step, or step where it should replay, or fail to return to the base address after the last frame of an auto run. It also checks that a held single-frame block ignores strobes until re-armed. A long memory latency forces underruns: a faulty design would skip words, shorten the frame or repeat the wrong word. Extra strobes during a frame must be counted, must not restart the address sequence, and must leave the frame intact.

// File: rtl/sws_pkg.sv
package sws_pkg;
  localparam int PIX_W        = 16;
  localparam int WORD_W       = 64;
  localparam int PIX_PER_WORD = WORD_W / PIX_W;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HALT = 2'd2,
    ST_WAIT = 2'd3
  } seq_state_e;

  typedef enum logic [1:0] {
    PM_SINGLE = 2'd0,
    PM_MULTI  = 2'd1,
    PM_AUTO   = 2'd2,
    PM_RSVD   = 2'd3
  } play_mode_e;

  function automatic logic [3:0] eff_div(input logic [3:0] d);
    return (d == 4'd0) ? 4'd1 : d;
  endfunction
endpackage

// File: rtl/sws_pacer.sv
module sws_pacer #(
  parameter int TICK_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic       en,
  input  logic [3:0] div_n,
  output logic       slot
);
  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

  logic [PRE_W-1:0] pre_q, pre_nx;
  logic [3:0]       nc_q, nc_nx;
  logic             tick;
  logic             cnt_en;

  assign tick   = en && (pre_q == PRE_LAST);
  assign slot   = tick && (nc_q == (div_n - 4'd1));
  assign cnt_en = restart || en;

  always_comb begin
    pre_nx = pre_q;
    nc_nx  = nc_q;
    if (restart) begin
      pre_nx = '0;
      nc_nx  = '0;
    end else if (en) begin
      pre_nx = tick ? '0 : pre_q + PRE_W'(1);
      if (tick) nc_nx = slot ? 4'd0 : nc_q + 4'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      nc_q  <= '0;
    end else if (cnt_en) begin
      pre_q <= pre_nx;
      nc_q  <= nc_nx;
    end
  end
endmodule

// File: rtl/sws_fetch.sv
module sws_fetch #(
  parameter int ADDR_W      = 24,
  parameter int FRAME_WORDS = 65536,
  parameter int CNT_W       = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              active,
  input  logic [ADDR_W-1:0] base,
  input  logic              consume,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [63:0]       mem_rdata,
  output logic              buf_valid,
  output logic [63:0]       buf_data
);
  localparam logic [CNT_W-1:0] WORDS = CNT_W'(FRAME_WORDS);

  logic [CNT_W-1:0] req_q, req_nx;
  logic             pend_q, pend_nx;
  logic             bv_q, bv_nx;
  logic [63:0]      bd_q;
  logic             need;
  logic             bd_en;

  assign need     = active && !bv_q && !pend_q && (req_q < WORDS);
  assign mem_req  = need;
  assign mem_addr = base + ADDR_W'(req_q);
  assign bd_en    = mem_rvalid && !start;
  assign buf_valid = bv_q;
  assign buf_data  = bd_q;

  always_comb begin
    req_nx  = req_q;
    pend_nx = pend_q;
    bv_nx   = bv_q;
    if (start) begin
      req_nx  = '0;
      pend_nx = 1'b0;
      bv_nx   = 1'b0;
    end else begin
      if (need) begin
        req_nx  = req_q + CNT_W'(1);
        pend_nx = 1'b1;
      end
      if (consume) bv_nx = 1'b0;
      if (mem_rvalid) begin
        bv_nx   = 1'b1;
        pend_nx = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= '0;
      pend_q <= 1'b0;
      bv_q   <= 1'b0;
    end else begin
      req_q  <= req_nx;
      pend_q <= pend_nx;
      bv_q   <= bv_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bd_q <= '0;
    else if (bd_en)  bd_q <= mem_rdata;
  end
endmodule

// File: rtl/sws_unpack.sv
module sws_unpack
  import sws_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_new,
  input  logic              load_rep,
  input  logic [WORD_W-1:0] new_word,
  output logic              pix_valid,
  output logic [PIX_W-1:0]  pix_data,
  output logic              underrun
);
  localparam int LEFT_W = $clog2(PIX_PER_WORD + 1);

  logic [WORD_W-1:0] sreg_q, sreg_nx;
  logic [WORD_W-1:0] hold_q;
  logic [LEFT_W-1:0] left_q, left_nx;
  logic              rep_q, rep_nx;
  logic              shift_en;

  assign pix_valid = (left_q != '0);
  assign pix_data  = sreg_q[WORD_W-1 -: PIX_W];
  assign underrun  = rep_q;
  assign shift_en  = load_new || load_rep || pix_valid;

  always_comb begin
    sreg_nx = sreg_q;
    left_nx = left_q;
    rep_nx  = 1'b0;
    if (load_new) begin
      sreg_nx = new_word;
      left_nx = LEFT_W'(PIX_PER_WORD);
    end else if (load_rep) begin
      sreg_nx = hold_q;
      left_nx = LEFT_W'(PIX_PER_WORD);
      rep_nx  = 1'b1;
    end else if (pix_valid) begin
      sreg_nx = {sreg_q[WORD_W-PIX_W-1:0], {PIX_W{1'b0}}};
      left_nx = left_q - LEFT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
      left_q <= '0;
      rep_q  <= 1'b0;
    end else if (shift_en) begin
      sreg_q <= sreg_nx;
      left_q <= left_nx;
      rep_q  <= rep_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         hold_q <= '0;
    else if (load_new)  hold_q <= new_word;
  end
endmodule

// File: rtl/scene_word_sequencer.sv
module scene_word_sequencer
  import sws_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int FRAME_WORDS = 65536,
  parameter int TICK_DIV    = 4,
  parameter int FCNT_W      = 16,
  parameter int DROP_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic [1:0]        cfg_mode,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [3:0]        cfg_div,
  input  logic [FCNT_W-1:0] cfg_frames,
  input  logic              cfg_arm,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [63:0]       mem_rdata,
  output logic              pix_valid,
  output logic [15:0]       pix_data,
  output logic              underrun,
  output logic              busy,
  output logic [DROP_W-1:0] drop_count
);
  localparam int CNT_W = $clog2(FRAME_WORDS + 1);
  localparam logic [CNT_W-1:0]  LAST_IDX  = CNT_W'(FRAME_WORDS - 1);
  localparam logic [ADDR_W-1:0] FRAME_SPAN = ADDR_W'(FRAME_WORDS);
  localparam logic [DROP_W-1:0] DROP_MAX  = {DROP_W{1'b1}};

  seq_state_e        st_q, st_nx;
  play_mode_e        mode_q, mode_nx;
  logic [3:0]        n_q, n_nx;
  logic [ADDR_W-1:0] base_q, base_nx;
  logic [FCNT_W-1:0] left_q, left_nx;
  logic [CNT_W-1:0]  sent_q, sent_nx;
  logic [DROP_W-1:0] drop_q, drop_nx;

  logic        run;
  logic        slot;
  logic        buf_valid;
  logic [63:0] buf_data;
  logic        fire_new, fire_rep;
  logic        last_word;
  logic        begin_frame;

  assign run         = (st_q == ST_RUN);
  assign fire_new    = slot && buf_valid;
  assign fire_rep    = slot && !buf_valid;
  assign last_word   = fire_new && (sent_q == LAST_IDX);
  assign begin_frame = frame_start &&
                       ((st_q == ST_IDLE) || ((st_q == ST_WAIT) && !cfg_arm));
  assign busy        = run;
  assign drop_count  = drop_q;

  sws_pacer #(.TICK_DIV(TICK_DIV)) u_pacer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (begin_frame),
    .en      (run),
    .div_n   (n_q),
    .slot    (slot)
  );

  sws_fetch #(.ADDR_W(ADDR_W), .FRAME_WORDS(FRAME_WORDS), .CNT_W(CNT_W)) u_fetch (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (begin_frame),
    .active     (run),
    .base       (base_q),
    .consume    (fire_new),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata),
    .buf_valid  (buf_valid),
    .buf_data   (buf_data)
  );

  sws_unpack u_unpack (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_new  (fire_new),
    .load_rep  (fire_rep),
    .new_word  (buf_data),
    .pix_valid (pix_valid),
    .pix_data  (pix_data),
    .underrun  (underrun)
  );

  // next-state logic
  always_comb begin
    st_nx   = st_q;
    mode_nx = mode_q;
    n_nx    = n_q;
    base_nx = base_q;
    left_nx = left_q;
    sent_nx = sent_q;
    drop_nx = drop_q;

    if (begin_frame) begin
      n_nx    = eff_div(cfg_div);
      sent_nx = '0;
    end else if (fire_new) begin
      sent_nx = sent_q + CNT_W'(1);
    end

    if (run && frame_start && (drop_q != DROP_MAX))
      drop_nx = drop_q + DROP_W'(1);

    unique case (st_q)
      ST_IDLE: begin
        if (frame_start) begin
          st_nx   = ST_RUN;
          mode_nx = play_mode_e'(cfg_mode);
          base_nx = cfg_base;
          left_nx = (cfg_frames == '0) ? FCNT_W'(1) : cfg_frames;
        end
      end
      ST_RUN: begin
        if (last_word) begin
          unique case (mode_q)
            PM_MULTI: st_nx = ST_IDLE;
            PM_AUTO: begin
              if (left_q == FCNT_W'(1)) begin
                st_nx = ST_IDLE;
              end else begin
                st_nx   = ST_WAIT;
                left_nx = left_q - FCNT_W'(1);
                base_nx = base_q + FRAME_SPAN;
              end
            end
            default: st_nx = ST_HALT;
          endcase
        end
      end
      ST_HALT: begin
        if (cfg_arm) st_nx = ST_IDLE;
      end
      ST_WAIT: begin
        if (cfg_arm)          st_nx = ST_IDLE;
        else if (frame_start) st_nx = ST_RUN;
      end
      default: st_nx = ST_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      mode_q <= PM_SINGLE;
      n_q    <= 4'd1;
      base_q <= '0;
      left_q <= '0;
      sent_q <= '0;
      drop_q <= '0;
    end else begin
      st_q   <= st_nx;
      mode_q <= mode_nx;
      n_q    <= n_nx;
      base_q <= base_nx;
      left_q <= left_nx;
      sent_q <= sent_nx;
      drop_q <= drop_nx;
    end
  end
endmodule

// File: rtl/sws_checker.sv
module sws_checker #(
  parameter int DROP_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_start,
  input logic              mem_req,
  input logic              busy,
  input logic              pix_valid,
  input logic              underrun,
  input logic [DROP_W-1:0] drop_count
);
  // R4: a request is never followed by another one on the next clock
  p_one_outstanding_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  // R10: no memory traffic outside a frame
  p_quiet_when_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

  // R9: the drop counter only ever steps up by one
  p_drop_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_count != $past(drop_count)) |-> (drop_count == $past(drop_count) + DROP_W'(1)));

  // R9: the drop counter moves only after a strobe during a frame
  p_drop_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_count != $past(drop_count)) |-> ($past(frame_start) && $past(busy)));

  // R8: the underrun mark rides on a valid pixel
  p_underrun_on_pixel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> pix_valid);

  // R3: pixel bursts are longer than one clock
  p_burst_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pix_valid) |=> pix_valid);
endmodule

bind scene_word_sequencer sws_checker #(.DROP_W(DROP_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .frame_start (frame_start),
  .mem_req     (mem_req),
  .busy        (busy),
  .pix_valid   (pix_valid),
  .underrun    (underrun),
  .drop_count  (drop_count)
);

// File: tb/sim_scene_word_sequencer.sv
module sim_scene_word_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int W  = 6;
  localparam int TD = 4;
  localparam int FW = 8;
  localparam int DW = 8;

  logic          clk, rst_n, frame_start, cfg_arm;
  logic [1:0]    cfg_mode;
  logic [AW-1:0] cfg_base;
  logic [3:0]    cfg_div;
  logic [FW-1:0] cfg_frames;
  logic          mem_req, mem_rvalid;
  logic [AW-1:0] mem_addr;
  logic [63:0]   mem_rdata;
  logic          pix_valid, underrun, busy;
  logic [15:0]   pix_data;
  logic [DW-1:0] drop_count;

  scene_word_sequencer #(.ADDR_W(AW), .FRAME_WORDS(W), .TICK_DIV(TD),
                         .FCNT_W(FW), .DROP_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .cfg_mode(cfg_mode),
    .cfg_base(cfg_base), .cfg_div(cfg_div), .cfg_frames(cfg_frames),
    .cfg_arm(cfg_arm), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .pix_valid(pix_valid),
    .pix_data(pix_data), .underrun(underrun), .busy(busy), .drop_count(drop_count)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  int mem_lat = 1;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [63:0] wdata(input logic [15:0] a);
    return {a, ~a, a ^ 16'h5A5A, a + 16'h0001};
  endfunction

  // reference model state
  int          ms, mmode, mN, mleft, mcnt, mreq, msent, mpl, mdrop;
  logic [15:0] mbase;
  bit          mbv, mpend, mrep;
  logic [63:0] mbuf, msreg, mhold;

  always @(posedge clk) begin
    if (!rst_n) begin
      ms = 0; mmode = 0; mN = 1; mleft = 0; mcnt = 0; mreq = 0; msent = 0;
      mpl = 0; mdrop = 0; mbase = '0; mbv = 0; mpend = 0; mrep = 0;
      mbuf = '0; msreg = '0; mhold = '0;
    end else begin
      bit slot, fnew, frep, req, startf;
      int eff;
      slot = (ms == 1) && (mcnt == 0);
      fnew = slot && mbv;
      frep = slot && !mbv;
      req  = (ms == 1) && !mbv && !mpend && (mreq < W);
      eff  = (cfg_div == 0) ? 1 : int'(cfg_div);
      startf = 0;
      if (fnew)      begin msreg = mbuf; mhold = mbuf; mpl = 4; mrep = 0; end
      else if (frep) begin msreg = mhold; mpl = 4; mrep = 1; end
      else if (mpl > 0) begin msreg = msreg << 16; mpl--; mrep = 0; end
      if (fnew) mbv = 0;
      if (req) begin mpend = 1; mreq++; end
      if (mem_rvalid) begin mbv = 1; mbuf = mem_rdata; mpend = 0; end
      if (ms == 1) mcnt = slot ? TD * mN - 1 : mcnt - 1;
      if (ms == 1 && frame_start && mdrop < 255) mdrop++;
      case (ms)
        0: if (frame_start) begin
             startf = 1; mmode = cfg_mode; mbase = cfg_base;
             mleft = (cfg_frames == 0) ? 1 : int'(cfg_frames);
           end
        1: if (fnew) begin
             if (msent == W - 1) begin
               if (mmode == 1) ms = 0;
               else if (mmode == 2) begin
                 if (mleft == 1) ms = 0;
                 else begin mleft--; mbase = mbase + 16'(W); ms = 3; end
               end else ms = 2;
             end else msent++;
           end
        2: if (cfg_arm) ms = 0;
        default: if (cfg_arm) ms = 0; else if (frame_start) startf = 1;
      endcase
      if (startf) begin
        ms = 1; mN = eff; mcnt = TD * eff - 1; mreq = 0; mbv = 0; mpend = 0; msent = 0;
      end
    end
  end

  // monitors, memory and comparison
  logic [15:0] frame_addrs[$], req_q[$], pix_q[$];
  int          word_times[$];
  int          pcnt = 0, under_cnt = 0, word_cnt = 0;
  bit          prev_busy = 0, mp = 0;
  int          mw = 0;
  logic [15:0] ma;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      bit ereq;
      ereq = (ms == 1) && !mbv && !mpend && (mreq < W);
      chk(pix_valid == (mpl != 0), "R3 pix_valid", pix_valid, mpl != 0);
      if (mpl != 0) chk(pix_data == msreg[63:48], "R3 pix_data", pix_data, msreg[63:48]);
      chk(mem_req == ereq, "R4 mem_req", mem_req, ereq);
      if (ereq) chk(mem_addr == mbase + 16'(mreq), "R4 mem_addr", mem_addr, mbase + 16'(mreq));
      chk(underrun == mrep, "R8 underrun", underrun, mrep);
      chk(busy == (ms == 1), "R10 busy", busy, ms == 1);
      chk(drop_count == DW'(mdrop), "R9 drop_count", drop_count, mdrop);
      if (busy && !prev_busy && mem_req) frame_addrs.push_back(mem_addr);
      if (mem_req) req_q.push_back(mem_addr);
      if (pix_valid) begin
        pix_q.push_back(pix_data);
        if (pcnt == 0) begin word_times.push_back(cyc); word_cnt++; end
        pcnt = (pcnt + 1) % 4;
      end
      if (underrun) under_cnt++;
      prev_busy = busy;
    end
    mem_rvalid = 1'b0;
    if (!rst_n) mp = 0;
    else begin
      if (mp) begin
        if (mw == 0) begin mem_rvalid = 1'b1; mem_rdata = wdata(ma); mp = 0; end
        else mw--;
      end
      if (mem_req) begin mp = 1; mw = mem_lat; ma = mem_addr; end
    end
    if (cyc > 150000) begin
      chk(0, "watchdog", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic pulse_start();
    @(negedge clk) frame_start = 1'b1;
    @(negedge clk) frame_start = 1'b0;
  endtask

  task automatic pulse_arm();
    @(negedge clk) cfg_arm = 1'b1;
    @(negedge clk) cfg_arm = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    do begin @(negedge clk); n++; end while ((busy || pix_valid) && n < 3000);
    chk(n < 3000, "frame watchdog", n, 3000);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    rst_n = 0; frame_start = 0; cfg_arm = 0; cfg_mode = 2'd1; cfg_base = 16'h0100;
    cfg_div = 4'd1; cfg_frames = '0; mem_rvalid = 0; mem_rdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(pix_valid == 0 && mem_req == 0 && busy == 0 && underrun == 0,
        "R1 outputs after reset", {pix_valid, mem_req, busy, underrun}, 0);
    chk(drop_count == 0, "R1 drop_count after reset", drop_count, 0);

    // multiple-frame replay
    frame_addrs.delete(); req_q.delete(); pix_q.delete();
    pulse_start(); wait_done(); pulse_start(); wait_done();
    chk(frame_addrs.size() == 2, "R6 frame count", frame_addrs.size(), 2);
    foreach (frame_addrs[i]) chk(frame_addrs[i] == 16'h0100, "R6 replay base", frame_addrs[i], 16'h0100);
    chk(req_q.size() == 2 * W, "R4 request count", req_q.size(), 2 * W);
    foreach (req_q[i]) chk(req_q[i] == 16'h0100 + 16'(i % W), "R4 address order", req_q[i], 16'h0100 + 16'(i % W));
    for (int k = 0; k < 4; k++)
      chk(pix_q[k] == wdata(16'h0100)[63 - 16*k -: 16], "R3 big-endian order",
          pix_q[k], wdata(16'h0100)[63 - 16*k -: 16]);

    // pacing
    cfg_div = 4'd3; word_times.delete();
    pulse_start(); wait_done();
    chk(word_times[1] - word_times[0] == 3 * TD, "R2 spacing N=3", word_times[1] - word_times[0], 3 * TD);
    cfg_div = 4'd0; word_times.delete();
    pulse_start(); wait_done();
    chk(word_times[1] - word_times[0] == TD, "R2 spacing N=0", word_times[1] - word_times[0], TD);

    // strobes during a frame
    cfg_div = 4'd1; frame_addrs.delete();
    pulse_start(); pulse_start(); pulse_start(); pulse_start();
    wait_done();
    chk(drop_count == 3, "R9 dropped strobes", drop_count, 3);
    chk(frame_addrs.size() == 1, "R9 frame not restarted", frame_addrs.size(), 1);

    // single-frame
    cfg_mode = 2'd0; frame_addrs.delete();
    pulse_start(); wait_done(); pulse_start();
    repeat (20) @(negedge clk);
    chk(busy == 0 && frame_addrs.size() == 1, "R5 held after one frame", frame_addrs.size(), 1);
    pulse_arm(); pulse_start(); wait_done();
    chk(frame_addrs.size() == 2, "R5 re-arm", frame_addrs.size(), 2);
    pulse_arm(); cfg_mode = 2'd3;
    pulse_start(); wait_done(); pulse_start();
    repeat (20) @(negedge clk);
    chk(frame_addrs.size() == 3, "R5 code 3 as single", frame_addrs.size(), 3);

    // auto-repeat
    pulse_arm(); cfg_mode = 2'd2; cfg_frames = 8'd3; cfg_base = 16'h0200; frame_addrs.delete();
    repeat (4) begin pulse_start(); wait_done(); end
    chk(frame_addrs.size() == 4, "R7 frames", frame_addrs.size(), 4);
    for (int k = 0; k < 3; k++)
      chk(frame_addrs[k] == 16'h0200 + 16'(k * W), "R7 movie step", frame_addrs[k], 16'h0200 + 16'(k * W));
    chk(frame_addrs[3] == 16'h0200, "R7 back to base after run", frame_addrs[3], 16'h0200);
    pulse_arm(); cfg_frames = '0; cfg_base = 16'h0300; frame_addrs.delete();
    repeat (2) begin pulse_start(); wait_done(); end
    chk(frame_addrs[0] == 16'h0300 && frame_addrs[1] == 16'h0300, "R7 zero count as one",
        frame_addrs[1], 16'h0300);

    // underrun
    cfg_mode = 2'd1; cfg_base = 16'h0400; mem_lat = 6; under_cnt = 0; word_cnt = 0; req_q.delete();
    pulse_start(); wait_done();
    chk(under_cnt > 0, "R8 underrun seen", under_cnt, 1);
    chk(word_cnt == W + under_cnt, "R8 all words delivered", word_cnt, W + under_cnt);
    chk(req_q.size() == W, "R8 fetch count", req_q.size(), W);
    mem_lat = 1;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule